// File: doc/BRIEF.md
# Threshold-Based Two-Path Loop Predictor

This block guesses, for a loop whose iterations almost always follow one of two hot paths through the body, which of those two paths the coming iteration will take. Speculative multithreading hardware uses the guess to choose which thread code to spawn. The two candidates are the primary path, meaning the most frequent one, and the secondary path.

A shift register holds a short record of recent iterations, one bit per iteration: 1 if that iteration followed the primary path. That record selects one saturating counter from a table. Each counter learns how often the primary path came next after its pattern. When a prediction is requested, the selected counter is compared with a run-time threshold. A count at or above the threshold gives a primary guess. A lower count gives a secondary guess.

When the loop reports how an iteration actually went, the counter selected by the pre-update history is adjusted first. The outcome bit is then shifted into the history.

Top module: `path_pair_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter reads zero. With `pred_req` high, a threshold of 0 then gives `pred_primary`=1 and a threshold of 1 gives 0.
- R2: On a clock edge with `resolve_vld`=1, the history shifts one place toward its MSB. The new LSB is `resolve_primary`, where 1 means the primary path and 0 means any other path.
- R3: The counter used for predicting and for updating is the one whose index equals the current history value. The table has 2^HIST_W counters.
- R4: On a resolve with `resolve_primary`=1, the selected counter increments by one. The counter is chosen by the history value before that edge's shift.
- R5: An increment on a counter already at 2^CNT_W-1 leaves it at 2^CNT_W-1.
- R6: On a resolve with `resolve_primary`=0, the selected counter decrements by one. A counter already at 0 stays at 0.
- R7: `pred_primary` is combinational and valid in the cycle of the request. With `pred_req`=1 it is 1 exactly when the selected counter is greater than or equal to the unsigned `threshold`. With `pred_req`=0 it is 0.
- R8: Cycles with `resolve_vld`=0 change neither the history nor any counter, whatever `pred_req` and `threshold` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_req | input | 1 | Prediction request; gates `pred_primary` |
| resolve_vld | input | 1 | One iteration has resolved this cycle |
| resolve_primary | input | 1 | Resolved iteration took the primary path |
| threshold | input | CNT_W | Minimum count that gives a primary guess |
| pred_primary | output | 1 | 1: primary path guessed, 0: secondary path |

## Verification
The bench overrides the defaults and builds the block with a 3-bit history and 3-bit counters. With eight counters that each saturate at 7, a few hundred random resolves drive every table entry into both the upper and the lower saturation limits. Every threshold value from 0 to the maximum is also reachable, including the values just above and just below each count. A directed run of primary outcomes pins one counter at its ceiling. A run of secondary outcomes from reset holds a counter at zero.

// File: rtl/ppp_pkg.sv
package ppp_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_INC  = 2'd1,
    UPD_DEC  = 2'd2
  } upd_op_e;

  localparam int unsigned HIST_W_MIN = 1;
  localparam int unsigned HIST_W_MAX = 16;
endpackage

// File: rtl/ppp_history.sv
module ppp_history #(
  parameter int unsigned HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = shift_bit;
    end else begin : g_many
      assign hist_d = {hist_q[HIST_W-2:0], shift_bit};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/ppp_counter_table.sv
module ppp_counter_table #(
  parameter int unsigned HIST_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [HIST_W-1:0]             upd_idx,
  input  ppp_pkg::upd_op_e              upd_op,
  output logic [(CNT_W<<HIST_W)-1:0]    cnt_flat
);
  import ppp_pkg::*;

  localparam int unsigned DEPTH = 1 << HIST_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                 input upd_op_e op);
    logic [CNT_W-1:0] res;
    res = cur;
    case (op)
      UPD_INC: if (cur != CNT_MAX) res = cur + 1'b1;
      UPD_DEC: if (cur != '0)      res = cur - 1'b1;
      default: res = cur;
    endcase
    return res;
  endfunction

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      logic [CNT_W-1:0] c_q;
      logic             hit;
      assign hit = (upd_idx == HIST_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      c_q <= '0;
        else if (hit && upd_op != UPD_HOLD) c_q <= next_count(c_q, upd_op);
      end
      assign cnt_flat[g*CNT_W +: CNT_W] = c_q;
    end
  endgenerate
endmodule

// File: rtl/path_pair_predictor.sv
module path_pair_predictor #(
  parameter int unsigned HIST_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_req,
  input  logic             resolve_vld,
  input  logic             resolve_primary,
  input  logic [CNT_W-1:0] threshold,
  output logic             pred_primary
);
  import ppp_pkg::*;

  localparam int unsigned DEPTH = 1 << HIST_W;

  function automatic logic meets_threshold(input logic [CNT_W-1:0] cnt,
                                           input logic [CNT_W-1:0] thr);
    return cnt >= thr;
  endfunction

  logic [HIST_W-1:0]        hist;
  logic [CNT_W*DEPTH-1:0]   cnt_flat;
  logic [CNT_W-1:0]         sel_cnt;
  upd_op_e                  upd_op;
  logic                     upd_inc;
  logic                     upd_dec;

  assign upd_inc = resolve_vld &&  resolve_primary;
  assign upd_dec = resolve_vld && !resolve_primary;
  assign upd_op  = upd_inc ? UPD_INC : (upd_dec ? UPD_DEC : UPD_HOLD);

  ppp_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (resolve_vld),
    .shift_bit (resolve_primary),
    .hist      (hist)
  );

  ppp_counter_table #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_idx  (hist),
    .upd_op   (upd_op),
    .cnt_flat (cnt_flat)
  );

  assign sel_cnt      = cnt_flat[int'(hist)*CNT_W +: CNT_W];
  assign pred_primary = pred_req && meets_threshold(sel_cnt, threshold);
endmodule

// File: rtl/ppp_checker.sv
module ppp_checker #(
  parameter int unsigned HIST_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         pred_req,
  input logic                         resolve_vld,
  input logic                         resolve_primary,
  input logic [CNT_W-1:0]             threshold,
  input logic                         pred_primary,
  input logic [HIST_W-1:0]            hist,
  input logic [(CNT_W<<HIST_W)-1:0]   cnt_flat,
  input logic [CNT_W-1:0]             sel_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              seen_q;
  logic              res_q;
  logic              prim_q;
  logic [HIST_W-1:0] hist_q;
  logic [CNT_W-1:0]  sel_q;
  logic [CNT_W-1:0]  now_at_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0; res_q <= 1'b0; prim_q <= 1'b0;
      hist_q <= '0;   sel_q <= '0;
    end else begin
      seen_q <= 1'b1; res_q <= resolve_vld; prim_q <= resolve_primary;
      hist_q <= hist; sel_q <= sel_cnt;
    end
  end

  assign now_at_prev = cnt_flat[int'(hist_q)*CNT_W +: CNT_W];

  AST_HIST_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_vld |=> hist[0] == $past(resolve_primary)); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && res_q && prim_q && sel_q != CNT_MAX) |-> now_at_prev == sel_q + 1'b1); // R4
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && res_q && prim_q && sel_q == CNT_MAX) |-> now_at_prev == CNT_MAX); // R5
  AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && res_q && !prim_q) |-> now_at_prev == ((sel_q == '0) ? sel_q : sel_q - 1'b1)); // R6
  AST_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_req && threshold == '0) |-> pred_primary); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_vld |=> ($stable(hist) && $stable(cnt_flat))); // R8
endmodule

bind path_pair_predictor ppp_checker #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .resolve_vld(resolve_vld),
  .resolve_primary(resolve_primary), .threshold(threshold),
  .pred_primary(pred_primary), .hist(hist), .cnt_flat(cnt_flat), .sel_cnt(sel_cnt)
);

// File: tb/path_pair_predictor_tb.sv
`timescale 1ns/1ps
module path_pair_predictor_tb;
  localparam int HW = 3;
  localparam int CW = 3;
  localparam int NCNT = 1 << HW;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_req = 1'b0;
  logic resolve_vld = 1'b0;
  logic resolve_primary = 1'b0;
  logic [CW-1:0] threshold = '0;
  logic pred_primary;

  int n_checks = 0;
  int n_fail = 0;
  int m_cnt [NCNT];
  int m_hist = 0;

  always #2 clk = ~clk;

  path_pair_predictor #(.HIST_W(HW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .resolve_vld(resolve_vld),
    .resolve_primary(resolve_primary), .threshold(threshold), .pred_primary(pred_primary)
  );

  function automatic int model_next(input int cur, input bit prim);
    int v;
    v = prim ? cur + 1 : cur - 1;
    if (v > CMAX) v = CMAX;
    if (v < 0) v = 0;
    return v;
  endfunction

  function automatic bit model_pred(input bit req, input int thr);
    if (!req) return 1'b0;
    return !(m_cnt[m_hist] < thr);
  endfunction

  task automatic check(input string req_tag, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pred_primary=%0b expected %0b (hist=%0d thr=%0d)",
               req_tag, act, exp, m_hist, threshold);
    end
  endtask

  task automatic probe(input string req_tag, input bit req, input int thr);
    @(negedge clk);
    resolve_vld = 1'b0; pred_req = req; threshold = CW'(thr);
    #1 check(req_tag, pred_primary, model_pred(req, thr));
  endtask

  task automatic resolve(input bit prim);
    @(negedge clk);
    resolve_vld = 1'b1; resolve_primary = prim;
    @(posedge clk);
    m_cnt[m_hist] = model_next(m_cnt[m_hist], prim);
    m_hist = ((m_hist << 1) | int'(prim)) & (NCNT - 1);
    @(negedge clk);
    resolve_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; resolve_vld = 1'b0;
    foreach (m_cnt[i]) m_cnt[i] = 0;
    m_hist = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    do_reset();
    // R1 reset state
    probe("R1", 1'b1, 0);
    probe("R1", 1'b1, 1);
    // R7 request gating
    probe("R7", 1'b0, 0);
    // R5 saturation: a long primary run pins counter 7 at its maximum
    for (int i = 0; i < 12; i++) resolve(1'b1);
    probe("R5", 1'b1, CMAX);
    probe("R3", 1'b1, CMAX);
    // R6 floor: secondary run from reset keeps counter 0 at zero
    do_reset();
    for (int i = 0; i < 5; i++) resolve(1'b0);
    probe("R6", 1'b1, 1);
    probe("R6", 1'b1, 0);
    // R2 R4: one primary then secondary; counter 0 is 1, history returns through 0b010
    resolve(1'b1);
    resolve(1'b0);
    probe("R2", 1'b1, 1);
    // R8 idle cycles with wandering request and threshold
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      pred_req = 1'($urandom); threshold = CW'($urandom);
    end
    for (int t = 0; t <= CMAX; t++) probe("R8", 1'b1, t);
    // random mix, checked against the model
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 9) < 7) resolve(1'($urandom_range(0, 9) < 6));
      probe("R2/R3/R4/R6/R7", 1'($urandom_range(0, 7) != 0), $urandom_range(0, CMAX));
    end
    // R1 reset mid-run clears learnt state
    do_reset();
    probe("R1", 1'b1, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule